// File: doc/BRIEF.md
# Block Transfer Address Generator

This block sequences the memory side of load-multiple and store-multiple operations. A request carries a base address, a 16-bit register mask, one of four addressing modes and a writeback flag. After a start strobe the block puts out one word address and one register index per cycle, qualified by a valid strobe. It then pulses done, together with the updated base value when an update is due. The memory and the register file sit outside the block.

The same sequencer also serves a single-register transfer with a signed offset. It then issues exactly one access and gives pre-indexed or post-indexed base handling.

For multi-register requests the block counts the set bits of the mask and works out the lowest address from that count and the mode. It then always walks upward: the lowest-numbered register goes to the lowest address.

Top module: `blk_xfer_agen`

## Requirements
- R1: Multi mode code 0 (increment-after): N accesses, the first at base, each next one 4 bytes higher; the updated base is base+4N.
- R2: Multi mode code 1 (increment-before): the first access is at base+4 and the last at base+4N; the updated base is base+4N.
- R3: Multi mode code 2 (decrement-after): the first access is at base−4N+4 and the last at base; the updated base is base−4N.
- R4: Multi mode code 3 (decrement-before): the first access is at base−4N and the last at base−4; the updated base is base−4N. Arithmetic wraps modulo 2^ADDR_W.
- R5: Registers are issued in ascending index order, one per set mask bit (bit i means register i), while addresses rise by 4 per access. This holds in every mode.
- R6: N equals the popcount of the mask. The k-th access (k=1..N) is valid in the k-th cycle after the start edge, and done is high for exactly the next cycle.
- R7: For a multi-register request, wb_valid rises with done only when wback=1. With wback=0 no updated base is reported.
- R8: With single=1 and mode code 0 (pre-index, update), one access is made at base+offset to register sreg, and the updated base base+offset is reported.
- R9: With single=1 and mode code 1 (pre-index, no update), one access is made at base+offset and wb_valid stays low. Code 3 behaves the same.
- R10: With single=1 and mode code 2 (post-index), one access is made at base and the updated base base+offset is reported.
- R11: A multi-register request with an all-zero mask makes no access, raises done in the first cycle after the start edge, and reports no updated base.
- R12: start is ignored while busy is high, and input changes made during a sequence do not alter it.
- R13: After reset, and in the cycle after done, busy, acc_valid, done and wb_valid are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| single | input | 1 | 1 selects a single-register transfer |
| mode | input | 2 | Addressing mode code (multi or single, see requirements) |
| wback | input | 1 | Base update enable for multi-register requests |
| base | input | ADDR_W (32) | Base address |
| mask | input | NREG (16) | Register mask for multi-register requests |
| offset | input | ADDR_W (32) | Two's-complement offset for single transfers |
| sreg | input | IDX_W (4) | Register index for single transfers |
| busy | output | 1 | Sequence in progress, including the done cycle |
| acc_valid | output | 1 | Access address and register index are valid |
| acc_addr | output | ADDR_W (32) | Word address of the current access |
| acc_reg | output | IDX_W (4) | Register index of the current access |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Updated base is valid (only with done) |
| wb_addr | output | ADDR_W (32) | Updated base value |

## Verification
The assertions check on every cycle that consecutive valid accesses rise by exactly one word with strictly increasing register index. They also check that each access run ends in done, that done lasts one cycle and returns the block to idle, that wb_valid never appears without done, and that a start raised mid-sequence cannot break the run. Only the bench scenarios can show the absolute addresses: the start address derived from mode and popcount in each mode, the updated base values, and the offset handling of the three single modes. The same holds for the empty-mask timing, wrap-around below zero, and that inputs scrambled during a run are ignored.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

   typedef enum logic [1:0] {
      AM_INC_AFTER  = 2'd0,
      AM_INC_BEFORE = 2'd1,
      AM_DEC_AFTER  = 2'd2,
      AM_DEC_BEFORE = 2'd3
   } multi_mode_e;

   typedef enum logic [1:0] {
      SM_PRE_UPD  = 2'd0,
      SM_PRE_KEEP = 2'd1,
      SM_POST_UPD = 2'd2,
      SM_RSVD     = 2'd3
   } single_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } seq_state_e;

endpackage

// File: rtl/blkx_popcount.sv
module blkx_popcount #(
   parameter int W  = 16,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] cnt
);

   if (CW < $clog2(W + 1)) begin : g_bad_cw
      $error("blkx_popcount: count width too small");
   end

   always_comb begin
      cnt = '0;
      for (int i = 0; i < W; i++) begin
         cnt = cnt + CW'(vec[i]);
      end
   end

endmodule

// File: rtl/blkx_lowbit.sv
module blkx_lowbit #(
   parameter int W  = 16,
   parameter int IW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic [IW-1:0] idx
);

   logic [W-1:0] below;
   logic [W-1:0] first_hot;

   for (genvar i = 0; i < W; i++) begin : g_chain
      if (i == 0) begin : g_lsb
         assign below[i] = 1'b0;
      end else begin : g_up
         assign below[i] = below[i-1] | vec[i-1];
      end
      assign first_hot[i] = vec[i] & ~below[i];
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < W; i++) begin
         if (first_hot[i]) idx = idx | IW'(i);
      end
   end

endmodule

// File: rtl/blkx_addr_calc.sv
module blkx_addr_calc
   import blkx_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 5,
   parameter int WORD_BYTES = 4
) (
   input  logic              single,
   input  logic [1:0]        mode,
   input  logic              wback,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] offset,
   input  logic [CNT_W-1:0]  cnt,
   output logic [ADDR_W-1:0] first_addr,
   output logic [ADDR_W-1:0] upd_addr,
   output logic              upd_en
);

   localparam int WSHIFT = $clog2(WORD_BYTES);
   localparam logic [ADDR_W-1:0] WSTEP = ADDR_W'(WORD_BYTES);

   logic [ADDR_W-1:0] span;
   logic [ADDR_W-1:0] up_end;
   logic [ADDR_W-1:0] dn_end;
   logic [ADDR_W-1:0] off_sum;
   multi_mode_e       mm;
   single_mode_e      sm;

   assign span    = ADDR_W'(cnt) << WSHIFT;
   assign up_end  = base + span;
   assign dn_end  = base - span;
   assign off_sum = base + offset;
   assign mm      = multi_mode_e'(mode);
   assign sm      = single_mode_e'(mode);

   always_comb begin
      first_addr = base;
      upd_addr   = base;
      upd_en     = 1'b0;
      if (single) begin
         case (sm)
            SM_PRE_UPD: begin
               first_addr = off_sum;
               upd_addr   = off_sum;
               upd_en     = 1'b1;
            end
            SM_POST_UPD: begin
               first_addr = base;
               upd_addr   = off_sum;
               upd_en     = 1'b1;
            end
            default: begin
               first_addr = off_sum;
               upd_addr   = base;
               upd_en     = 1'b0;
            end
         endcase
      end else begin
         upd_en = wback && (cnt != '0);
         case (mm)
            AM_INC_AFTER: begin
               first_addr = base;
               upd_addr   = up_end;
            end
            AM_INC_BEFORE: begin
               first_addr = base + WSTEP;
               upd_addr   = up_end;
            end
            AM_DEC_AFTER: begin
               first_addr = dn_end + WSTEP;
               upd_addr   = dn_end;
            end
            default: begin
               first_addr = dn_end;
               upd_addr   = dn_end;
            end
         endcase
      end
   end

endmodule

// File: rtl/blk_xfer_agen.sv
module blk_xfer_agen
   import blkx_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int NREG       = 16,
   parameter int WORD_BYTES = 4,
   localparam int IDX_W     = $clog2(NREG),
   localparam int CNT_W     = $clog2(NREG + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              single,
   input  logic [1:0]        mode,
   input  logic              wback,
   input  logic [ADDR_W-1:0] base,
   input  logic [NREG-1:0]   mask,
   input  logic [ADDR_W-1:0] offset,
   input  logic [IDX_W-1:0]  sreg,
   output logic              busy,
   output logic              acc_valid,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [IDX_W-1:0]  acc_reg,
   output logic              done,
   output logic              wb_valid,
   output logic [ADDR_W-1:0] wb_addr
);

   localparam logic [ADDR_W-1:0] WSTEP = ADDR_W'(WORD_BYTES);

   if ((WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
      $error("blk_xfer_agen: WORD_BYTES must be a power of two");
   end
   if (NREG < 2) begin : g_bad_nreg
      $error("blk_xfer_agen: NREG must be at least 2");
   end
   if (ADDR_W <= CNT_W + $clog2(WORD_BYTES)) begin : g_bad_aw
      $error("blk_xfer_agen: ADDR_W too narrow for the largest span");
   end

   seq_state_e        state_q;
   logic [NREG-1:0]   rem_q;
   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] upd_q;
   logic              upd_en_q;

   logic [NREG-1:0]   load_mask;
   logic [NREG-1:0]   rem_next;
   logic [CNT_W-1:0]  mask_cnt;
   logic [ADDR_W-1:0] calc_first;
   logic [ADDR_W-1:0] calc_upd;
   logic              calc_upd_en;
   logic              take;

   assign load_mask = single ? (NREG'(1) << sreg) : mask;
   assign rem_next  = rem_q & (rem_q - NREG'(1));
   assign take      = start && (state_q == ST_IDLE);

   blkx_popcount #(.W(NREG), .CW(CNT_W)) u_pop (
      .vec (mask),
      .cnt (mask_cnt)
   );

   blkx_addr_calc #(
      .ADDR_W     (ADDR_W),
      .CNT_W      (CNT_W),
      .WORD_BYTES (WORD_BYTES)
   ) u_calc (
      .single     (single),
      .mode       (mode),
      .wback      (wback),
      .base       (base),
      .offset     (offset),
      .cnt        (mask_cnt),
      .first_addr (calc_first),
      .upd_addr   (calc_upd),
      .upd_en     (calc_upd_en)
   );

   blkx_lowbit #(.W(NREG), .IW(IDX_W)) u_low (
      .vec (rem_q),
      .idx (acc_reg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         rem_q    <= '0;
         cur_q    <= '0;
         upd_q    <= '0;
         upd_en_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (take) begin
                  rem_q    <= load_mask;
                  cur_q    <= calc_first;
                  upd_q    <= calc_upd;
                  upd_en_q <= calc_upd_en;
                  state_q  <= (load_mask == '0) ? ST_FIN : ST_RUN;
               end
            end
            ST_RUN: begin
               rem_q <= rem_next;
               cur_q <= cur_q + WSTEP;
               if (rem_next == '0) state_q <= ST_FIN;
            end
            default: begin
               state_q  <= ST_IDLE;
               upd_en_q <= 1'b0;
            end
         endcase
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign acc_valid = (state_q == ST_RUN);
   assign acc_addr  = cur_q;
   assign done      = (state_q == ST_FIN);
   assign wb_valid  = done && upd_en_q;
   assign wb_addr   = upd_q;

endmodule

// File: rtl/blkx_chk.sv
module blkx_chk #(
   parameter int ADDR_W     = 32,
   parameter int IDX_W      = 4,
   parameter int WORD_BYTES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              acc_valid,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [IDX_W-1:0]  acc_reg,
   input logic              done,
   input logic              wb_valid
);

   localparam logic [ADDR_W-1:0] WSTEP = ADDR_W'(WORD_BYTES);

   // R5: addresses climb one word per access, register indices climb too
   assert_ascend_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && $past(acc_valid)) |->
         (acc_addr == $past(acc_addr) + WSTEP) && (acc_reg > $past(acc_reg)));

   // R6: an access is followed by another access or by done
   assert_run_ends_in_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> (acc_valid || done));

   // R6: accesses only happen inside a busy window and never with done
   assert_valid_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> (busy && !done));

   // R7: an updated base is only reported with done
   assert_wb_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> done);

   // R12: a start during a run keeps the block busy, no restart or drop
   assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && start) |=> busy);

   // R13: done is a single pulse that returns the block to idle
   assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy && !acc_valid));

endmodule

bind blk_xfer_agen blkx_chk #(
   .ADDR_W     (ADDR_W),
   .IDX_W      (IDX_W),
   .WORD_BYTES (WORD_BYTES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .acc_valid (acc_valid),
   .acc_addr  (acc_addr),
   .acc_reg   (acc_reg),
   .done      (done),
   .wb_valid  (wb_valid)
);

// File: tb/tb_blk_xfer_agen.sv
module tb_blk_xfer_agen;

   localparam int AW = 32;
   localparam int NR = 16;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          single = 1'b0;
   logic [1:0]    mode = '0;
   logic          wback = 1'b0;
   logic [AW-1:0] base = '0;
   logic [NR-1:0] mask = '0;
   logic [AW-1:0] offset = '0;
   logic [IW-1:0] sreg = '0;
   logic          busy, acc_valid, done, wb_valid;
   logic [AW-1:0] acc_addr, wb_addr;
   logic [IW-1:0] acc_reg;

   int errors = 0;
   int checks = 0;
   int cyc    = 0;

   always #10 clk = ~clk;

   blk_xfer_agen #(.ADDR_W(AW), .NREG(NR), .WORD_BYTES(4)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .single(single), .mode(mode),
      .wback(wback), .base(base), .mask(mask), .offset(offset), .sreg(sreg),
      .busy(busy), .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_reg(acc_reg),
      .done(done), .wb_valid(wb_valid), .wb_addr(wb_addr)
   );

   typedef struct packed {
      logic          sgl;
      logic [1:0]    md;
      logic          wb;
      logic [31:0]   bs;
      logic [15:0]   mk;
      logic [31:0]   off;
      logic [3:0]    sr;
      logic [31:0]   first;
      logic [4:0]    n;
      logic          wbv;
      logic [31:0]   wba;
      logic [7:0]    rq;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      // R1 increment-after, registers 1..3
      '{1'b0, 2'd0, 1'b1, 32'h0008_0010, 16'h000E, 32'h0, 4'd0, 32'h0008_0010, 5'd3, 1'b1, 32'h0008_001C, 8'd1},
      // R2 increment-before, registers 0 and 15
      '{1'b0, 2'd1, 1'b1, 32'h0000_1000, 16'h8001, 32'h0, 4'd0, 32'h0000_1004, 5'd2, 1'b1, 32'h0000_1008, 8'd2},
      // R3 decrement-after, registers 4..7
      '{1'b0, 2'd2, 1'b1, 32'h0000_2000, 16'h00F0, 32'h0, 4'd0, 32'h0000_1FF4, 5'd4, 1'b1, 32'h0000_1FF0, 8'd3},
      // R4 decrement-before, sparse mask
      '{1'b0, 2'd3, 1'b1, 32'h0000_3000, 16'h0505, 32'h0, 4'd0, 32'h0000_2FF0, 5'd4, 1'b1, 32'h0000_2FF0, 8'd4},
      // R7 increment-after without update
      '{1'b0, 2'd0, 1'b0, 32'h0000_4000, 16'h0003, 32'h0, 4'd0, 32'h0000_4000, 5'd2, 1'b0, 32'h0, 8'd7},
      // R4 decrement-before, full mask, wraps below zero
      '{1'b0, 2'd3, 1'b1, 32'h0000_0010, 16'hFFFF, 32'h0, 4'd0, 32'hFFFF_FFD0, 5'd16, 1'b1, 32'hFFFF_FFD0, 8'd4},
      // R8 single pre-index with update
      '{1'b1, 2'd0, 1'b0, 32'h0000_5000, 16'h0000, 32'h0000_0020, 4'd7, 32'h0000_5020, 5'd1, 1'b1, 32'h0000_5020, 8'd8},
      // R9 single pre-index, negative offset, no update
      '{1'b1, 2'd1, 1'b1, 32'h0000_5000, 16'hFFFF, 32'hFFFF_FFF8, 4'd3, 32'h0000_4FF8, 5'd1, 1'b0, 32'h0, 8'd9},
      // R10 single post-index
      '{1'b1, 2'd2, 1'b0, 32'h0000_6000, 16'h0000, 32'h0000_0010, 4'd15, 32'h0000_6000, 5'd1, 1'b1, 32'h0000_6010, 8'd10},
      // R11 empty mask with update requested
      '{1'b0, 2'd0, 1'b1, 32'h0000_7000, 16'h0000, 32'h0, 4'd0, 32'h0, 5'd0, 1'b0, 32'h0, 8'd11},
      // R3 decrement-after, one register
      '{1'b0, 2'd2, 1'b1, 32'h0000_0100, 16'h0001, 32'h0, 4'd0, 32'h0000_0100, 5'd1, 1'b1, 32'h0000_00FC, 8'd3}
   };

   task automatic check(input bit ok, input int rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL R%0d %s actual=0x%08h expected=0x%08h", rq, what, act, exp);
      end
   endtask

   function automatic logic [3:0] nth_bit(input logic [15:0] m, input int k);
      int seen = 0;
      nth_bit = '0;
      for (int i = 0; i < 16; i++) begin
         if (m[i]) begin
            if (seen == k) nth_bit = 4'(i);
            seen++;
         end
      end
   endfunction

   task automatic run_case(input vec_t v, input bit hold);
      int c;
      int k;
      @(negedge clk);
      single = v.sgl; mode = v.md; wback = v.wb; base = v.bs;
      mask = v.mk; offset = v.off; sreg = v.sr;
      start = 1'b1;
      @(negedge clk);
      if (hold) begin
         // R12: keep start high and change every request input
         base = 32'h0000_9000; mask = 16'h0001; mode = 2'd3; single = 1'b0;
         wback = 1'b0; offset = 32'h40;
      end else begin
         start = 1'b0;
      end
      c = 1;
      k = 0;
      while (!done && c < 40) begin
         check(acc_valid, v.rq, "access valid", 32'(acc_valid), 32'd1);
         check(acc_addr == v.first + 32'(4 * k), v.rq, "access address",
               acc_addr, v.first + 32'(4 * k));
         if (v.sgl) check(acc_reg == v.sr, v.rq, "access register", 32'(acc_reg), 32'(v.sr));
         else check(acc_reg == nth_bit(v.mk, k), v.rq, "access register (R5 order)",
                    32'(acc_reg), 32'(nth_bit(v.mk, k)));
         k++;
         @(negedge clk);
         c++;
      end
      check(done && !acc_valid, v.rq, "done without access", 32'(done), 32'd1);
      check(c == int'(v.n) + 1, v.rq, "done cycle (R6)", 32'(c), 32'(v.n) + 32'd1);
      check(k == int'(v.n), v.rq, "access count (R6)", 32'(k), 32'(v.n));
      check(wb_valid == v.wbv, v.rq, "update valid", 32'(wb_valid), 32'(v.wbv));
      if (v.wbv) check(wb_addr == v.wba, v.rq, "updated base", wb_addr, v.wba);
      start = 1'b0;
      @(negedge clk);
      check(!busy && !done && !acc_valid && !wb_valid, 13, "idle after done (R13)",
            {28'd0, busy, done, acc_valid, wb_valid}, 32'd0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL R6 watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      // R13: reset state, with start held high during reset
      start = 1'b1;
      repeat (3) @(negedge clk);
      check(!busy && !acc_valid && !done && !wb_valid, 13, "reset outputs (R13)",
            {28'd0, busy, acc_valid, done, wb_valid}, 32'd0);
      start = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !acc_valid, 13, "idle after reset release (R13)",
            {30'd0, busy, acc_valid}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         run_case(VECS[i], 1'b0);
      end

      // R12: start held and inputs scrambled during an increment-after run
      run_case('{1'b0, 2'd0, 1'b1, 32'h0000_A000, 16'h00F0, 32'h0, 4'd0,
                 32'h0000_A000, 5'd4, 1'b1, 32'h0000_A010, 8'd12}, 1'b1);

      // R11: empty mask back to back with a normal request
      run_case(VECS[9], 1'b0);
      run_case(VECS[0], 1'b0);

      // R9: reserved single code behaves as pre-index without update
      run_case('{1'b1, 2'd3, 1'b1, 32'h0000_0800, 16'h0, 32'h0000_0004, 4'd9,
                 32'h0000_0804, 5'd1, 1'b0, 32'h0, 8'd9}, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule